// File: doc/BRIEF.md
# Line Transceiver Power Status Monitor

This block watches the two power-status pins of a subscriber-line transceiver and turns them into protocol actions that depend on the operating side of the line. On the network-termination or terminal side it copies the two pin levels into two maintenance overhead bits of the outgoing line frame. The first pin reports the primary supply and the second reports the secondary supply.

On the line-termination side the two pins change meaning. A rising level on the first pin means the remote feed to the subscriber line has been switched off. The block then raises a one-cycle request that forces the core state machine into its TEST state. It also presents the fixed indication code 4'b0011 on its command/indication output for as long as the pin stays high. The second pin becomes a serial input. An external power controller shifts in an 8-bit feed-current value, MSB first, during a bit slot that follows the serial-port data-in timing. The finished value is latched and flagged with a one-cycle valid pulse.

Both pins pass through a two-stage synchroniser before any logic uses them. Frame assembly, the activation state machine and the serial-port framer lie outside the block and appear only as ports.

Top module: `pwr_status_mon`

## Requirements
- R1: With `lt_mode` low, `oh_primary` equals the level of `ps_primary` sampled two clock edges earlier.
- R2: With `lt_mode` low, `oh_secondary` equals the level of `ps_secondary` sampled two clock edges earlier.
- R3: With `lt_mode` high, `oh_primary` and `oh_secondary` are both 1.
- R4: With `lt_mode` high, a low-to-high change of the synchronised `ps_primary` gives exactly one cycle of `test_req`. If the pin is first seen high at edge k, the pulse is high after edge k+2. A level that stays high gives no further pulse.
- R5: `ci_code` becomes 4'b0011 at the same edge as the `test_req` pulse. It stays 4'b0011 while `lt_mode` and the synchronised `ps_primary` stay high. Otherwise it is 4'b1111.
- R6: With `lt_mode` and `slot_en` high, each `bit_strobe` shifts the synchronised `ps_secondary` in, MSB first. On the eighth strobe the value is written to `feed_cur`, and `feed_valid` is high for that one cycle.
- R7: A low `slot_en` discards a partly received value, so the next slot starts again at the MSB. `feed_cur` holds its value between completed captures.
- R8: With `lt_mode` low, `test_req` stays 0, `ci_code` stays 4'b1111, strobes are ignored, `feed_valid` stays 0 and `feed_cur` does not change.
- R9: After synchronous reset, `oh_primary` and `oh_secondary` are 0, `ci_code` is 4'b1111, `test_req` is 0, `feed_cur` is 0 and `feed_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_mode | input | 1 | 1 = line-termination side, 0 = network/terminal side |
| ps_primary | input | 1 | First power-status pin (asynchronous) |
| ps_secondary | input | 1 | Second power-status pin / serial current data |
| slot_en | input | 1 | High for the duration of the 8-bit current slot |
| bit_strobe | input | 1 | One-cycle strobe per serial bit, aligned to the data-in bit timing |
| oh_primary | output | 1 | Primary-supply overhead bit for the outgoing frame |
| oh_secondary | output | 1 | Secondary-supply overhead bit for the outgoing frame |
| ci_code | output | 4 | Command/indication code toward the processor |
| test_req | output | 1 | One-cycle request to force the TEST state |
| feed_cur | output | 8 | Last captured feed-current value |
| feed_valid | output | 1 | One-cycle pulse when `feed_cur` is updated |

## Verification
A synchroniser stage that is stuck or skipped shows up on the overhead bits within two cycles as a level that is wrong or one cycle off. A faulty edge-history register shows up at the first power-loss event as a missing pulse or a repeated `test_req`. A wrong indication code, or a hold that ends too early or too late, shows on `ci_code` in the cycle the pin level changes. A bit counter or shift register that is out of step does not show until the end of a slot, when the eighth strobe lands a wrong byte, or a pulse at the wrong strobe, on `feed_cur` and `feed_valid`.

// File: rtl/pwr_mon_pkg.sv
package pwr_mon_pkg;

    typedef enum logic {
        OPM_NTTE = 1'b0,
        OPM_LT   = 1'b1
    } op_mode_e;

    localparam int CI_W = 4;
    localparam logic [CI_W-1:0] CI_POWER_OFF = 4'b0011;
    localparam logic [CI_W-1:0] CI_IDLE      = 4'b1111;

    typedef struct packed {
        logic primary;
        logic secondary;
    } pin_pair_t;

    typedef struct packed {
        logic            hi_active;
        logic            test_pulse;
    } alarm_state_t;

    function automatic op_mode_e decode_mode(input logic lt);
        return lt ? OPM_LT : OPM_NTTE;
    endfunction

    function automatic logic [CI_W-1:0] ci_for(input logic hi);
        return hi ? CI_POWER_OFF : CI_IDLE;
    endfunction

endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/pwr_loss_detect.sv
module pwr_loss_detect
    import pwr_mon_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  op_mode_e        mode,
    input  logic            loss_lvl,
    output logic [CI_W-1:0] ci_code,
    output logic            test_req
);
    logic         lvl_prev;
    alarm_state_t st;
    logic         loss_rise;

    assign loss_rise = (mode == OPM_LT) && loss_lvl && !lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= 1'b0;
            st       <= '0;
        end else begin
            lvl_prev      <= loss_lvl;
            st.test_pulse <= loss_rise;
            st.hi_active  <= loss_rise ||
                             (st.hi_active && loss_lvl && (mode == OPM_LT));
        end
    end

    assign ci_code  = ci_for(st.hi_active);
    assign test_req = st.test_pulse;

    p_test_single_r4: assert property (@(posedge clk) disable iff (rst)
        test_req |=> !test_req);
    p_test_with_hi_r5: assert property (@(posedge clk) disable iff (rst)
        test_req |-> (ci_code == CI_POWER_OFF));
    p_hi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ((ci_code == CI_POWER_OFF) && loss_lvl && (mode == OPM_LT)) |=> (ci_code == CI_POWER_OFF));
    p_ntte_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == OPM_NTTE) |=> !test_req);
endmodule

// File: rtl/pwr_feed_capture.sv
module pwr_feed_capture
    import pwr_mon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  op_mode_e          mode,
    input  logic              slot_en,
    input  logic              bit_strobe,
    input  logic              ser_bit,
    output logic [DATA_W-1:0] value,
    output logic              valid
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] next_shreg;
    logic              take;

    assign take       = (mode == OPM_LT) && slot_en && bit_strobe;
    assign next_shreg = {shreg[DATA_W-2:0], ser_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
            value <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (mode != OPM_LT || !slot_en) begin
                cnt <= '0;
            end else if (take) begin
                shreg <= next_shreg;
                if (cnt == LAST) begin
                    cnt   <= '0;
                    value <= next_shreg;
                    valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    p_value_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(value));
    p_ntte_no_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == OPM_NTTE) |=> !valid);
endmodule

// File: rtl/pwr_status_mon.sv
module pwr_status_mon
    import pwr_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CUR_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lt_mode,
    input  logic             ps_primary,
    input  logic             ps_secondary,
    input  logic             slot_en,
    input  logic             bit_strobe,
    output logic             oh_primary,
    output logic             oh_secondary,
    output logic [CI_W-1:0]  ci_code,
    output logic             test_req,
    output logic [CUR_W-1:0] feed_cur,
    output logic             feed_valid
);
    localparam int PIN_W = $bits(pin_pair_t);

    op_mode_e   mode;
    pin_pair_t  raw_pins;
    pin_pair_t  sync_pins;
    logic [PIN_W-1:0] sync_vec;

    assign mode     = decode_mode(lt_mode);
    assign raw_pins = '{primary: ps_primary, secondary: ps_secondary};

    pwr_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_pins),
        .sync_o  (sync_vec)
    );
    assign sync_pins = pin_pair_t'(sync_vec);

    // Overhead bits: level copy on NT/TE side, forced to 1 on LT side
    always_comb begin
        if (mode == OPM_LT) begin
            oh_primary   = 1'b1;
            oh_secondary = 1'b1;
        end else begin
            oh_primary   = sync_pins.primary;
            oh_secondary = sync_pins.secondary;
        end
    end

    pwr_loss_detect i_loss (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .loss_lvl (sync_pins.primary),
        .ci_code  (ci_code),
        .test_req (test_req)
    );

    pwr_feed_capture #(.DATA_W(CUR_W)) i_feed (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .slot_en    (slot_en),
        .bit_strobe (bit_strobe),
        .ser_bit    (sync_pins.secondary),
        .value      (feed_cur),
        .valid      (feed_valid)
    );

    p_oh_tracks_r1: assert property (@(posedge clk) disable iff (rst)
        (!lt_mode && $past(!rst)) |-> (oh_primary == sync_pins.primary));
    p_feed_needs_slot_r6: assert property (@(posedge clk) disable iff (rst)
        feed_valid |-> ($past(slot_en) && $past(bit_strobe) && $past(lt_mode)));
endmodule

// File: tb/test_pwr_status_mon.sv
module test_pwr_status_mon;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lt_mode = 1'b0, ps_primary = 1'b0, ps_secondary = 1'b0;
    logic slot_en = 1'b0, bit_strobe = 1'b0;
    logic oh_primary, oh_secondary, test_req, feed_valid;
    logic [3:0] ci_code;
    logic [7:0] feed_cur;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_status_mon i_pwr_status_mon (
        .clk(clk), .rst(rst), .lt_mode(lt_mode),
        .ps_primary(ps_primary), .ps_secondary(ps_secondary),
        .slot_en(slot_en), .bit_strobe(bit_strobe),
        .oh_primary(oh_primary), .oh_secondary(oh_secondary),
        .ci_code(ci_code), .test_req(test_req),
        .feed_cur(feed_cur), .feed_valid(feed_valid)
    );

    // Behavioural reference: queues model pin delay, integers model the slot
    bit  qa[$], qb[$];
    bit  m_prev, m_hi, m_test, m_valid;
    int  m_cnt, m_sh, m_cur;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin qa = '{0, 0}; qb = '{0, 0}; end

    always @(posedge clk) begin
        bit a2, b2, rise;
        a2 = qa[0]; b2 = qb[0];
        if (rst) begin
            m_prev = 0; m_hi = 0; m_test = 0; m_valid = 0;
            m_cnt = 0; m_sh = 0; m_cur = 0;
            qa = '{0, 0}; qb = '{0, 0};
        end else begin
            rise   = lt_mode && a2 && !m_prev;
            m_test = rise;
            m_hi   = rise || (m_hi && a2 && lt_mode);
            m_prev = a2;
            m_valid = 0;
            if (!lt_mode || !slot_en) m_cnt = 0;
            else if (bit_strobe) begin
                m_sh = ((m_sh << 1) | b2) & 8'hFF;
                if (m_cnt == 7) begin m_cur = m_sh; m_valid = 1; m_cnt = 0; end
                else m_cnt++;
            end
            void'(qa.pop_front()); qa.push_back(ps_primary);
            void'(qb.pop_front()); qb.push_back(ps_secondary);
        end
    end

    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            chk(lt_mode ? "R3 oh_primary"   : "R1 oh_primary",   oh_primary,   lt_mode ? 1 : qa[0]);
            chk(lt_mode ? "R3 oh_secondary" : "R2 oh_secondary", oh_secondary, lt_mode ? 1 : qb[0]);
            chk("R4 test_req", test_req, m_test);
            chk("R5 ci_code", ci_code, m_hi ? 4'b0011 : 4'b1111);
            chk("R6 feed_valid", feed_valid, m_valid);
            chk("R7 feed_cur", feed_cur, m_cur);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        ps_secondary = b;
        cyc(3);
        bit_strobe = 1; cyc(1); bit_strobe = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        slot_en = 1;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        cyc(1);
        chk("R6 captured byte", feed_cur, v);
        slot_en = 0; cyc(2);
    endtask

    initial begin
        cyc(3);
        // R9: reset values visible during reset
        chk("R9 oh_primary", oh_primary, 0);
        chk("R9 oh_secondary", oh_secondary, 0);
        chk("R9 ci_code", ci_code, 4'b1111);
        chk("R9 test_req", test_req, 0);
        chk("R9 feed", {feed_valid, feed_cur}, 0);
        rst = 0; cyc(2);

        // R1/R2: NT/TE level copy, several patterns
        for (int p = 0; p < 8; p++) begin
            ps_primary = p[0]; ps_secondary = p[1];
            cyc(1 + p % 3);
        end
        ps_primary = 1; ps_secondary = 0; cyc(2);
        chk("R1 primary copy", oh_primary, 1);
        chk("R2 secondary copy", oh_secondary, 0);

        // R8: NT/TE ignores strobes and power-loss edges
        ps_primary = 0; cyc(3); ps_primary = 1; cyc(4);
        chk("R8 no test_req", test_req, 0);
        chk("R8 idle code", ci_code, 4'b1111);
        slot_en = 1;
        for (int i = 0; i < 9; i++) send_bit(i[0]);
        slot_en = 0; cyc(1);
        chk("R8 feed_cur unchanged", feed_cur, 0);

        // R3/R4/R5: LT side
        ps_primary = 0; cyc(3);
        lt_mode = 1; cyc(1);
        chk("R3 forced overhead", {oh_primary, oh_secondary}, 2'b11);
        ps_primary = 1; cyc(2);
        chk("R4 not yet", test_req, 0);
        cyc(1);
        chk("R4 pulse", test_req, 1);
        chk("R5 HI code", ci_code, 4'b0011);
        cyc(5);
        chk("R4 single pulse", test_req, 0);
        chk("R5 held", ci_code, 4'b0011);
        ps_primary = 0; cyc(4);
        chk("R5 back to idle", ci_code, 4'b1111);
        ps_primary = 1; cyc(1); ps_primary = 0; cyc(5);
        ps_primary = 1; cyc(6);

        // R6: serial captures
        send_byte(8'hA5);
        send_byte(8'h3C);
        send_byte(8'h81);

        // R7: aborted partial slot, then a clean one
        slot_en = 1;
        for (int i = 0; i < 5; i++) send_bit(1);
        slot_en = 0; cyc(2);
        chk("R7 hold after abort", feed_cur, 8'h81);
        send_byte(8'h5A);

        // mode drop while alarm active clears the code
        lt_mode = 0; cyc(2);
        chk("R5 idle in NT/TE", ci_code, 4'b1111);
        cyc(3);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule